// File: doc/BRIEF.md
# Adaptive Count-Rate Range Controller

This block sits beside a counter-based frequency synthesizer. The synthesizer counts the period of its input with one count rate and produces its output period with a second count rate. The block watches each period count that the synthesizer captures and holds that count inside a useful band. It does this by moving both count rates up or down together, so the ratio between the rates never changes. The programmed output-to-input frequency relation therefore stays the same, while a low count regains resolution and a high count stays clear of counter overrun.

Both count-enable strobes come from one shared prescaler on the system clock. The prescaler divides by a power of two chosen by a range index. At each capture a small state machine compares the count with a programmable low limit and a programmable high limit, and steps the index by at most one. After a step it discards the next capture, because that capture may straddle the change. Every other capture is passed on to the downstream logic.

The state machine has two states. In `ST_TRACK` every capture is judged. If the capture moves the index, the transition `TRACK->SETTLE` is taken. Otherwise the transition `TRACK->TRACK` is taken and the index holds. In `ST_SETTLE` the next capture is dropped and the transition `SETTLE->TRACK` is taken. Between captures each state holds.

Top module: `adaptive_rate_ctrl`

## Requirements
- R1: While reset is active and after it is released, `range_idx` is 0 and `meas_valid` is 0, and the block is in `ST_TRACK`.
- R2: `cnt1_en` and `cnt2_en` are equal on every cycle.
- R3: At range index r the enables divide the clock by 2^r. The prescaler restarts at every capture edge, so the first enable comes in the 2^r-th cycle after that edge, counting the cycle right after the edge as the first. At r = 0 the enables are high on every cycle.
- R4: In `ST_TRACK`, a capture with `cap_count` < `lo_limit` and index > 0 lowers the index by one at that clock edge.
- R5: In `ST_TRACK`, a capture with `cap_count` > `hi_limit` and index < 7 raises the index by one at that clock edge.
- R6: The index saturates. A low count at index 0, or a high count at index 7, leaves it unchanged and does not enter `ST_SETTLE`.
- R7: A count with `lo_limit` <= `cap_count` <= `hi_limit` leaves the index unchanged.
- R8: The index changes only in the cycle after a cycle with `cap_valid` high, and only by one.
- R9: The capture that causes a step is forwarded. The next capture after a step is dropped, with no `meas_valid` pulse, and the block returns to `ST_TRACK`.
- R10: A forwarded capture gives `meas_valid` high for one cycle, in the cycle after `cap_valid`, with `meas_count` equal to the captured value.
- R11: The capture dropped in `ST_SETTLE` causes no step, even when it lies outside the limits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | One-cycle strobe at each input-period boundary |
| cap_count | input | CW | Period count captured at that boundary |
| lo_limit | input | CW | Low limit; counts below it speed both rates up |
| hi_limit | input | CW | High limit; counts above it slow both rates down |
| cnt1_en | output | 1 | Enable for the period-measuring counter |
| cnt2_en | output | 1 | Enable for the output-generating counter |
| range_idx | output | RW | Current range index; the divide factor is 2^index |
| meas_valid | output | 1 | Forwarded-capture strobe |
| meas_count | output | CW | Forwarded captured count |

## Verification
The bench builds the block with its defaults: a 16-bit count and a 3-bit index, which gives divide factors from 1 to 128. With these values the bench can climb to the top index and the full 128-cycle enable spacing, and descend back to divide-by-1, inside a short run. It also changes the limits during the run, issues back-to-back captures so that a capture can be dropped in the very cycle after a step, and places counts exactly on each limit to test the edges of the hysteresis band.

// File: rtl/arc_pkg.sv
package arc_pkg;
    typedef enum logic {
        ST_TRACK  = 1'b0,
        ST_SETTLE = 1'b1
    } arc_state_t;
endpackage

// File: rtl/arc_prescaler.sv
module arc_prescaler #(
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [RW-1:0] range_sel,
    output logic          tick
);
    localparam int PW = (1 << RW) - 1;

    logic [PW-1:0] div_q;
    logic [PW-1:0] sel_mask;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    // Low range_sel bits of the divider all set marks the 2^range_sel-th cycle
    always_comb begin
        sel_mask = ~({PW{1'b1}} << range_sel);
        tick     = ((div_q & sel_mask) == sel_mask);
    end
endmodule

// File: rtl/arc_judge.sv
module arc_judge #(
    parameter int CW = 16,
    parameter int RW = 3
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] lo_limit,
    input  logic [CW-1:0] hi_limit,
    input  logic [RW-1:0] range_cur,
    output logic          step_down,
    output logic          step_up
);
    localparam logic [RW-1:0] TOP = {RW{1'b1}};

    always_comb begin
        step_down = (count < lo_limit) && (range_cur != '0);
        step_up   = (count > hi_limit) && (range_cur != TOP) && !(count < lo_limit);
    end
endmodule

// File: rtl/adaptive_rate_ctrl.sv
module adaptive_rate_ctrl
    import arc_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_valid,
    input  logic [CW-1:0] cap_count,
    input  logic [CW-1:0] lo_limit,
    input  logic [CW-1:0] hi_limit,
    output logic          cnt1_en,
    output logic          cnt2_en,
    output logic [RW-1:0] range_idx,
    output logic          meas_valid,
    output logic [CW-1:0] meas_count
);
    arc_state_t state_q, state_d;
    logic       step_down, step_up, tick;

    arc_judge #(.CW(CW), .RW(RW)) u_judge (
        .count     (cap_count),
        .lo_limit  (lo_limit),
        .hi_limit  (hi_limit),
        .range_cur (range_idx),
        .step_down (step_down),
        .step_up   (step_up)
    );

    arc_prescaler #(.RW(RW)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cap_valid),
        .range_sel (range_idx),
        .tick      (tick)
    );

    // Both counters share one tick, so their rate ratio never moves
    assign cnt1_en = tick;
    assign cnt2_en = tick;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK:  if (cap_valid && (step_up || step_down)) state_d = ST_SETTLE;
            ST_SETTLE: if (cap_valid) state_d = ST_TRACK;
            default:   state_d = ST_TRACK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_idx  <= '0;
            meas_valid <= 1'b0;
            meas_count <= '0;
        end else begin
            meas_valid <= 1'b0;
            unique case (state_q)
                ST_TRACK: begin
                    if (cap_valid) begin
                        meas_valid <= 1'b1;
                        meas_count <= cap_count;
                        if (step_down)    range_idx <= range_idx - 1'b1;
                        else if (step_up) range_idx <= range_idx + 1'b1;
                    end
                end
                ST_SETTLE: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/arc_checker.sv
module arc_checker #(
    parameter int CW = 16,
    parameter int RW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cap_valid,
    input logic [CW-1:0] cap_count,
    input logic [CW-1:0] lo_limit,
    input logic [CW-1:0] hi_limit,
    input logic          cnt1_en,
    input logic          cnt2_en,
    input logic [RW-1:0] range_idx,
    input logic          meas_valid,
    input logic [CW-1:0] meas_count
);
    logic [RW-1:0] prev_range;
    logic          owe_drop;
    logic          drop_due;

    assign drop_due = (range_idx != prev_range) || owe_drop;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_range <= '0;
            owe_drop   <= 1'b0;
        end else begin
            prev_range <= range_idx;
            owe_drop   <= cap_valid ? 1'b0 : drop_due;
        end
    end

    AST_ENABLES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        cnt1_en == cnt2_en); // R2
    AST_FULL_RATE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (range_idx == '0) |-> cnt1_en); // R3
    AST_STEP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(range_idx) |-> $past(cap_valid)); // R8
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(range_idx) |-> ((range_idx == $past(range_idx) + 1'b1) ||
                                 (range_idx == $past(range_idx) - 1'b1))); // R8
    AST_DROP_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && drop_due) |=> (!meas_valid && $stable(range_idx))); // R9
    AST_FORWARD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> ($past(cap_valid) && (meas_count == $past(cap_count)))); // R10
    AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && (cap_count >= lo_limit) && (cap_count <= hi_limit)) |=>
        $stable(range_idx)); // R7
endmodule

bind adaptive_rate_ctrl arc_checker #(.CW(CW), .RW(RW)) u_arc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_valid  (cap_valid),
    .cap_count  (cap_count),
    .lo_limit   (lo_limit),
    .hi_limit   (hi_limit),
    .cnt1_en    (cnt1_en),
    .cnt2_en    (cnt2_en),
    .range_idx  (range_idx),
    .meas_valid (meas_valid),
    .meas_count (meas_count)
);

// File: tb/adaptive_rate_ctrl_tb.sv
module adaptive_rate_ctrl_tb;
    localparam int CW = 16;
    localparam int RW = 3;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cap_valid;
    logic [CW-1:0] cap_count;
    logic [CW-1:0] lo_limit;
    logic [CW-1:0] hi_limit;
    logic          cnt1_en, cnt2_en, meas_valid;
    logic [RW-1:0] range_idx;
    logic [CW-1:0] meas_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    adaptive_rate_ctrl #(.CW(CW), .RW(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_count(cap_count),
        .lo_limit(lo_limit), .hi_limit(hi_limit), .cnt1_en(cnt1_en),
        .cnt2_en(cnt2_en), .range_idx(range_idx), .meas_valid(meas_valid),
        .meas_count(meas_count)
    );

    // Behavioural reference state
    int    m_range, m_cnt, m_fc;
    bit    m_settle, m_fv;
    int    vectors = 0, errors = 0, cycles = 0;
    bit    done = 1'b0;
    string req = "R1";

    task automatic model_edge();
        if (!rst_n) begin
            m_range = 0; m_cnt = 0; m_settle = 0; m_fv = 0; m_fc = 0;
        end else begin
            m_fv = 0;
            m_cnt = cap_valid ? 0 : (m_cnt + 1) % 128;
            if (cap_valid) begin
                if (m_settle) m_settle = 0;          // R11 dropped capture, no step
                else begin
                    m_fv = 1; m_fc = int'(cap_count);
                    if (int'(cap_count) < int'(lo_limit) && m_range > 0) begin
                        m_range--; m_settle = 1;
                    end else if (int'(cap_count) > int'(hi_limit) && m_range < 7) begin
                        m_range++; m_settle = 1;
                    end
                end
            end
        end
    endtask

    task automatic compare();
        bit exp_en;
        exp_en = ((m_cnt + 1) % (1 << m_range)) == 0;
        vectors++;
        if (cnt1_en !== exp_en || cnt2_en !== exp_en) begin
            errors++;
            $display("FAIL %s/R2/R3 enables: got %b/%b exp %b (range %0d)", req, cnt1_en, cnt2_en, exp_en, m_range);
        end
        if (int'(range_idx) != m_range) begin
            errors++;
            $display("FAIL %s range_idx: got %0d exp %0d", req, range_idx, m_range);
        end
        if (meas_valid !== m_fv) begin
            errors++;
            $display("FAIL %s/R10 meas_valid: got %b exp %b", req, meas_valid, m_fv);
        end else if (m_fv && int'(meas_count) != m_fc) begin
            errors++;
            $display("FAIL %s/R10 meas_count: got %0d exp %0d", req, meas_count, m_fc);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic capture(input int v, input int gap);
        cap_valid = 1'b1; cap_count = CW'(v);
        cycle();
        cap_valid = 1'b0;
        idle(gap);
    endtask

    initial begin
        rst_n = 1'b0; cap_valid = 1'b0; cap_count = '0;
        lo_limit = CW'(1024); hi_limit = CW'(32768);
        req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(4);
        // R6 low count at index 0 saturates
        req = "R6"; capture(10, 5); capture(10, 5);
        // R5 climb to the top; R9 each step followed by a dropped capture
        req = "R5";
        for (int k = 0; k < 7; k++) begin
            capture(40000, 140);
            req = "R9"; capture(40000, 140); req = "R5";
        end
        // R6 saturation at the top
        req = "R6"; capture(60000, 260); capture(60000, 260);
        // R7 band edges hold the index
        req = "R7"; capture(1024, 140); capture(32768, 140); capture(5000, 140);
        // R4 descend; R11 out-of-band drop causes no step, back-to-back captures
        req = "R4"; capture(100, 0);
        req = "R11"; capture(5, 0);
        req = "R4"; capture(100, 70);
        req = "R11"; capture(50000, 70);
        // R7 new limits during the run
        req = "R7"; lo_limit = CW'(200); hi_limit = CW'(300);
        capture(200, 40); capture(300, 40);
        req = "R4";
        for (int k = 0; k < 6; k++) begin
            capture(199, 20); req = "R9"; capture(0, 20); req = "R4";
        end
        req = "R3"; capture(250, 30); capture(250, 1); capture(250, 2);
        req = "R10"; capture(12345 % 300, 5);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                errors++;
                $display("FAIL watchdog expired during %s: got %0d cycles exp < %0d", req, cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end
endmodule